// File: doc/BRIEF.md
# Exception Entry Unit

This unit sits beside a processor pipeline and handles the moment a fault is taken. The pipeline raises one or more bits of a cause vector for a single cycle, together with the PC, the data virtual address, the instruction word, the access flags and two request attributes: page-table-entry load and prefetch. The unit picks the winning cause. One cycle later it issues a redirect pulse whose target is a handler base register plus a fixed per-cause offset.

In the same cycle the unit updates its fault-capture registers. These are the return address, the faulting data address, a packed status word, a formatted page-table address for the data side, and a tag and formatted address for the instruction side. Restart and skip rules decide the return address. The status word is packed from fields of the instruction word. Data-side capture is held off for page-table-entry loads and prefetches.

Three base registers sit behind a small write/read port: the handler base, the data page-table base and the instruction page-table base. A saturating event counter for each cause can be read through a select input.

Top module: `exc_entry_unit`

## Requirements
- R1: On a taken fault, `redir_pc_o` = handler base + cause offset. The cause is the bit index of `fault_req_i`, and the offsets are: 0 reset 0x0001, 1 machine check 0x0401, 2 instruction miss 0x0181, 3 instruction access violation 0x0081, 4 single data miss 0x0201, 5 double data miss 0x0281, 6 unaligned 0x0301, 7 data page fault/access violation 0x0381, 8 illegal opcode 0x0481, 9 float/vector disabled 0x0581, 10 arithmetic/overflow 0x0501, 11 privileged call 0x2001, 12 interrupt 0x0101.
- R2: `redir_valid_o` is high for exactly the one cycle after each cycle in which any `fault_req_i` bit is set. It is low otherwise.
- R3: When several bits are set together, the lowest bit index wins. Only the winner affects the outputs and the counters.
- R4: Every cause except interrupt (bit 12) loads `exc_addr_o` with the PC. An interrupt loads it only when PC[1:0] is 00; otherwise `exc_addr_o` keeps its value.
- R5: For the trap causes (bits 10 and 11), the value from R4 is then incremented by 4.
- R6: For a data-side cause (bits 4 to 7), `fault_va_o` takes the VA. `mm_stat_o` takes {insn[31:26] at 16:11, insn[25:21] at 10:6, flags[5:0] at 5:0}.
- R7: For a data-side cause, `va_form_o` = data page-table base OR (VA[42:13] << 3).
- R8: If `req_pte_i` or `req_pref_i` is high, a data-side fault leaves `fault_va_o`, `mm_stat_o` and `va_form_o` unchanged.
- R9: For an instruction-side cause (bits 2 and 3), `itag_o` takes the PC and `iva_form_o` = instruction page-table base OR (PC[42:13] << 3). The data-side registers do not change.
- R10: Each cause has an 8-bit counter that counts the faults it wins and saturates at 255. `cnt_rdata_o` shows the counter chosen by `cnt_sel_i` (same cause index as R1) and shows 0 for selects 13 to 15.
- R11: While `rst_ni` is low, all capture registers, base registers and counters are 0, `redir_valid_o` is 0 and `redir_pc_o` is 0x0001.
- R12: When `cfg_we_i` is high, `cfg_wdata_i` is written at the next edge to the register chosen by `cfg_addr_i`: 0 handler base, 1 data page-table base, 2 instruction page-table base. `cfg_rdata_o` reads the selected register combinationally, and address 3 reads 0.
- R13: In a cycle with no fault request, none of the capture registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_req_i | input | 13 | Fault cause request bits |
| pc_i | input | 64 | PC of the faulting instruction |
| va_i | input | 64 | Faulting data virtual address |
| insn_i | input | 32 | Faulting instruction word |
| acc_flags_i | input | 6 | Access flags for the status word |
| req_pte_i | input | 1 | Access was a page-table-entry load |
| req_pref_i | input | 1 | Access was a prefetch |
| cfg_we_i | input | 1 | Base register write enable |
| cfg_addr_i | input | 2 | Base register select |
| cfg_wdata_i | input | 64 | Base register write data |
| cfg_rdata_o | output | 64 | Selected base register |
| cnt_sel_i | input | 4 | Event counter select |
| cnt_rdata_o | output | 8 | Selected event counter |
| redir_valid_o | output | 1 | Redirect pulse |
| redir_pc_o | output | 64 | Handler target PC |
| exc_addr_o | output | 64 | Return address |
| fault_va_o | output | 64 | Captured data fault address |
| mm_stat_o | output | 17 | Packed fault status |
| va_form_o | output | 64 | Data formatted page-table address |
| itag_o | output | 64 | Instruction fault tag |
| iva_form_o | output | 64 | Instruction formatted page-table address |

## Verification
The checker assumes that a fault request is held for only one cycle and that the page-table-entry and prefetch attributes come from the same access. Its stability properties then read a quiet cycle as one that must leave the capture registers unchanged. The stimulus drives every request for a single cycle and leaves an idle cycle after it. Base-register writes happen only while no fault is pending, so each expected target uses a known base value.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCAUSE  = 13;
  localparam int CAUSE_W = 4;
  localparam int STAT_W  = 17;

  typedef enum logic [CAUSE_W-1:0] {
    C_RESET  = 4'd0,  C_MCHK   = 4'd1,  C_IMISS  = 4'd2,  C_IACV   = 4'd3,
    C_DMISS1 = 4'd4,  C_DMISS2 = 4'd5,  C_UNALGN = 4'd6,  C_DFAULT = 4'd7,
    C_OPDEC  = 4'd8,  C_FPDIS  = 4'd9,  C_ARITH  = 4'd10, C_PCALL  = 4'd11,
    C_INTR   = 4'd12
  } cause_e;

  function automatic logic [15:0] cause_vec(logic [CAUSE_W-1:0] c);
    case (cause_e'(c))
      C_RESET:  return 16'h0001;
      C_MCHK:   return 16'h0401;
      C_IMISS:  return 16'h0181;
      C_IACV:   return 16'h0081;
      C_DMISS1: return 16'h0201;
      C_DMISS2: return 16'h0281;
      C_UNALGN: return 16'h0301;
      C_DFAULT: return 16'h0381;
      C_OPDEC:  return 16'h0481;
      C_FPDIS:  return 16'h0581;
      C_ARITH:  return 16'h0501;
      C_PCALL:  return 16'h2001;
      C_INTR:   return 16'h0101;
      default:  return 16'h0001;
    endcase
  endfunction

  function automatic logic is_trap(logic [CAUSE_W-1:0] c);
    return (cause_e'(c) == C_ARITH) || (cause_e'(c) == C_PCALL);
  endfunction

  function automatic logic is_dside(logic [CAUSE_W-1:0] c);
    return (c >= C_DMISS1) && (c <= C_DFAULT);
  endfunction

  function automatic logic is_iside(logic [CAUSE_W-1:0] c);
    return (cause_e'(c) == C_IMISS) || (cause_e'(c) == C_IACV);
  endfunction

  // interrupts capture the PC only when it is word aligned
  function automatic logic restart_always(logic [CAUSE_W-1:0] c);
    return cause_e'(c) != C_INTR;
  endfunction
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int N = 13,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    hit_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/exc_evt_cnt.sv
module exc_evt_cnt #(
  parameter int N  = 13,
  parameter int CW = 8,
  localparam int SW = $clog2(N),
  localparam int NS = 2 ** SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [SW-1:0] idx_i,
  input  logic [SW-1:0] sel_i,
  output logic [CW-1:0] rdata_o
);
  logic [CW-1:0] cnt_q [NS];

  for (genvar g = 0; g < NS; g++) begin : g_cnt
    if (g < N) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q[g] <= '0;
        else if (hit_i && idx_i == SW'(g) && cnt_q[g] != {CW{1'b1}})
          cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end else begin : g_tie
      assign cnt_q[g] = '0;
    end
  end

  assign rdata_o = cnt_q[sel_i];
endmodule

// File: rtl/exc_fault_regs.sv
module exc_fault_regs
  import exc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int VA_BITS    = 43,
  parameter int PAGE_SHIFT = 13,
  localparam int VPN_W     = VA_BITS - PAGE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [CAUSE_W-1:0] idx_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    va_i,
  input  logic [31:0]        insn_i,
  input  logic [5:0]         flags_i,
  input  logic               pte_i,
  input  logic               pref_i,
  input  logic [XLEN-1:0]    dpt_base_i,
  input  logic [XLEN-1:0]    ipt_base_i,
  output logic [XLEN-1:0]    exc_addr_o,
  output logic [XLEN-1:0]    fault_va_o,
  output logic [STAT_W-1:0]  mm_stat_o,
  output logic [XLEN-1:0]    va_form_o,
  output logic [XLEN-1:0]    itag_o,
  output logic [XLEN-1:0]    iva_form_o
);
  logic [XLEN-1:0]   ea_base, ea_next, dform, iform;
  logic [STAT_W-1:0] stat_d;
  logic              d_cap, i_cap;
  logic              unused_insn;

  assign unused_insn = ^insn_i[20:0];

  always_comb begin
    ea_base = (restart_always(idx_i) || pc_i[1:0] == 2'b00) ? pc_i : exc_addr_o;
    ea_next = is_trap(idx_i) ? ea_base + XLEN'(4) : ea_base;
    d_cap   = hit_i && is_dside(idx_i) && !pte_i && !pref_i;
    i_cap   = hit_i && is_iside(idx_i);
    stat_d  = {insn_i[31:26], insn_i[25:21], flags_i};
    dform   = dpt_base_i | (XLEN'(va_i[VA_BITS-1:PAGE_SHIFT]) << 3);
    iform   = ipt_base_i | (XLEN'(pc_i[VA_BITS-1:PAGE_SHIFT]) << 3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_addr_o <= '0;
      fault_va_o <= '0;
      mm_stat_o  <= '0;
      va_form_o  <= '0;
      itag_o     <= '0;
      iva_form_o <= '0;
    end else begin
      if (hit_i) exc_addr_o <= ea_next;
      if (d_cap) begin
        fault_va_o <= va_i;
        mm_stat_o  <= stat_d;
        va_form_o  <= dform;
      end
      if (i_cap) begin
        itag_o     <= pc_i;
        iva_form_o <= iform;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int VA_BITS    = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int CNT_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCAUSE-1:0]  fault_req_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    va_i,
  input  logic [31:0]        insn_i,
  input  logic [5:0]         acc_flags_i,
  input  logic               req_pte_i,
  input  logic               req_pref_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [XLEN-1:0]    cfg_wdata_i,
  output logic [XLEN-1:0]    cfg_rdata_o,
  input  logic [CAUSE_W-1:0] cnt_sel_i,
  output logic [CNT_W-1:0]   cnt_rdata_o,
  output logic               redir_valid_o,
  output logic [XLEN-1:0]    redir_pc_o,
  output logic [XLEN-1:0]    exc_addr_o,
  output logic [XLEN-1:0]    fault_va_o,
  output logic [STAT_W-1:0]  mm_stat_o,
  output logic [XLEN-1:0]    va_form_o,
  output logic [XLEN-1:0]    itag_o,
  output logic [XLEN-1:0]    iva_form_o
);
  logic [XLEN-1:0]    hbase_q, dpt_q, ipt_q;
  logic               hit;
  logic [CAUSE_W-1:0] idx;

  exc_prio_enc #(.N(NCAUSE)) u_prio (
    .req_i (fault_req_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hbase_q <= '0;
      dpt_q   <= '0;
      ipt_q   <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        2'd0:    hbase_q <= cfg_wdata_i;
        2'd1:    dpt_q   <= cfg_wdata_i;
        2'd2:    ipt_q   <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr_i)
      2'd0:    cfg_rdata_o = hbase_q;
      2'd1:    cfg_rdata_o = dpt_q;
      2'd2:    cfg_rdata_o = ipt_q;
      default: cfg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= XLEN'(cause_vec(C_RESET));
    end else begin
      redir_valid_o <= hit;
      if (hit) redir_pc_o <= hbase_q + XLEN'(cause_vec(idx));
    end
  end

  exc_fault_regs #(
    .XLEN(XLEN), .VA_BITS(VA_BITS), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .idx_i      (idx),
    .pc_i       (pc_i),
    .va_i       (va_i),
    .insn_i     (insn_i),
    .flags_i    (acc_flags_i),
    .pte_i      (req_pte_i),
    .pref_i     (req_pref_i),
    .dpt_base_i (dpt_q),
    .ipt_base_i (ipt_q),
    .exc_addr_o (exc_addr_o),
    .fault_va_o (fault_va_o),
    .mm_stat_o  (mm_stat_o),
    .va_form_o  (va_form_o),
    .itag_o     (itag_o),
    .iva_form_o (iva_form_o)
  );

  exc_evt_cnt #(.N(NCAUSE), .CW(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .idx_i   (idx),
    .sel_i   (cnt_sel_i),
    .rdata_o (cnt_rdata_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCAUSE-1:0] fault_req_i,
  input logic              req_pte_i,
  input logic              req_pref_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              redir_valid_o,
  input logic [XLEN-1:0]   exc_addr_o,
  input logic [XLEN-1:0]   fault_va_o,
  input logic [STAT_W-1:0] mm_stat_o,
  input logic [XLEN-1:0]   va_form_o,
  input logic [XLEN-1:0]   itag_o,
  input logic [XLEN-1:0]   iva_form_o
);
  assert_pulse_on_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_req_i) |=> redir_valid_o);

  assert_no_pulse_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fault_req_i) |=> !redir_valid_o);

  assert_hold_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fault_req_i) |=> $stable(exc_addr_o) && $stable(fault_va_o) && $stable(mm_stat_o)
                        && $stable(va_form_o) && $stable(itag_o) && $stable(iva_form_o));

  assert_suppress_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_pte_i || req_pref_i) |=> $stable(fault_va_o) && $stable(mm_stat_o) && $stable(va_form_o));

  assert_reset_cause_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i[0] |=> exc_addr_o == $past(pc_i));
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fault_req_i   (fault_req_i),
  .req_pte_i     (req_pte_i),
  .req_pref_i    (req_pref_i),
  .pc_i          (pc_i),
  .redir_valid_o (redir_valid_o),
  .exc_addr_o    (exc_addr_o),
  .fault_va_o    (fault_va_o),
  .mm_stat_o     (mm_stat_o),
  .va_form_o     (va_form_o),
  .itag_o        (itag_o),
  .iva_form_o    (iva_form_o)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] fault_req = '0;
  logic [63:0] pc = '0, va = '0, cfg_wdata = '0;
  logic [31:0] insn = '0;
  logic [5:0]  flags = '0;
  logic        pte = 1'b0, pref = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [3:0]  cnt_sel = '0;
  logic [63:0] cfg_rdata, redir_pc, exc_addr, fault_va, va_form, itag, iva_form;
  logic [7:0]  cnt_rdata;
  logic [16:0] mm_stat;
  logic        redir_valid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  exc_entry_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fault_req_i(fault_req), .pc_i(pc), .va_i(va),
    .insn_i(insn), .acc_flags_i(flags), .req_pte_i(pte), .req_pref_i(pref),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cnt_sel_i(cnt_sel), .cnt_rdata_o(cnt_rdata),
    .redir_valid_o(redir_valid), .redir_pc_o(redir_pc), .exc_addr_o(exc_addr),
    .fault_va_o(fault_va), .mm_stat_o(mm_stat), .va_form_o(va_form),
    .itag_o(itag), .iva_form_o(iva_form)
  );

  typedef struct {
    logic [63:0] rpc, ea, fva, form, tag, iform;
    logic [16:0] st;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0, n_errors = 0;
  logic [63:0] m_hb = '0, m_db = '0, m_ib = '0;
  logic [63:0] m_ea = '0, m_fva = '0, m_form = '0, m_tag = '0, m_iform = '0;
  logic [16:0] m_st = '0;
  int          m_cnt [13];

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] vec_of(input int c);
    case (c)
      0: return 64'h0001;  1: return 64'h0401;  2: return 64'h0181;  3: return 64'h0081;
      4: return 64'h0201;  5: return 64'h0281;  6: return 64'h0301;  7: return 64'h0381;
      8: return 64'h0481;  9: return 64'h0581;  10: return 64'h0501; 11: return 64'h2001;
      default: return 64'h0101;
    endcase
  endfunction

  // driver: one-cycle request, expected item pushed to the scoreboard
  task automatic issue(input logic [12:0] req, input logic [63:0] p, input logic [63:0] v,
                       input logic [31:0] iw, input logic [5:0] fl, input logic a_pte, input logic a_pref);
    int   w;
    exp_t e;
    @(negedge clk);
    fault_req = req; pc = p; va = v; insn = iw; flags = fl; pte = a_pte; pref = a_pref;
    w = 0;
    for (int i = 12; i >= 0; i--) if (req[i]) w = i;
    if (w != 12 || p[1:0] == 2'b00) m_ea = p;
    if (w == 10 || w == 11) m_ea = m_ea + 64'd4;
    if (w >= 4 && w <= 7 && !a_pte && !a_pref) begin
      m_fva  = v;
      m_st   = {iw[31:26], iw[25:21], fl};
      m_form = m_db | ({21'b0, v[42:13]} << 3);
    end
    if (w == 2 || w == 3) begin
      m_tag   = p;
      m_iform = m_ib | ({21'b0, p[42:13]} << 3);
    end
    if (m_cnt[w] < 255) m_cnt[w]++;
    e.rpc = m_hb + vec_of(w); e.ea = m_ea; e.fva = m_fva; e.form = m_form;
    e.tag = m_tag; e.iform = m_iform; e.st = m_st;
    sb_q.push_back(e);
    @(negedge clk);
    fault_req = '0; pte = 1'b0; pref = 1'b0;
  endtask

  // monitor: compare every redirect pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && redir_valid) begin
      if (sb_q.size() == 0) begin
        check("R2", "unexpected pulse", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R1", "redir_pc", redir_pc, e.rpc);
        check("R4", "exc_addr", exc_addr, e.ea);
        check("R6", "fault_va", fault_va, e.fva);
        check("R6", "mm_stat", {47'b0, mm_stat}, {47'b0, e.st});
        check("R7", "va_form", va_form, e.form);
        check("R9", "itag", itag, e.tag);
        check("R9", "iva_form", iva_form, e.iform);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, input logic [63:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check("R12", "cfg_rdata", cfg_rdata, exp);
  endtask

  task automatic cnt_read(input logic [3:0] s, input int exp, input string req);
    @(negedge clk);
    cnt_sel = s;
    #1 check(req, "cnt_rdata", {56'b0, cnt_rdata}, 64'(exp));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "redir_valid", {63'b0, redir_valid}, 64'd0);
    check("R11", "redir_pc", redir_pc, 64'h1);
    check("R11", "exc_addr", exc_addr, 64'd0);
    check("R11", "fault_va", fault_va, 64'd0);
    check("R11", "itag", itag, 64'd0);
    check("R11", "cfg_rdata", cfg_rdata, 64'd0);
    check("R11", "cnt_rdata", {56'b0, cnt_rdata}, 64'd0);
    rst_ni = 1'b1;

    // R12 base registers
    m_hb = 64'h0000_0000_1000_0000; m_db = 64'h0000_0002_0000_0000; m_ib = 64'h0000_0004_0000_0000;
    cfg_write(2'd0, m_hb); cfg_write(2'd1, m_db); cfg_write(2'd2, m_ib);
    cfg_write(2'd3, 64'hdead_beef);
    cfg_read(2'd0, m_hb); cfg_read(2'd1, m_db); cfg_read(2'd2, m_ib); cfg_read(2'd3, 64'd0);

    // R1 R4 R5 R6 R7 R9: each cause alone
    for (int c = 0; c < 13; c++)
      issue(13'(1) << c, 64'h0000_0123_4560_0000 + 64'(c * 64'h2004), 64'h0000_07aa_5550_0000 + 64'(c * 64'h3008),
            32'h0000_0000 | (32'(c + 17) << 26) | (32'(c + 3) << 21), 6'(c + 5), 1'b0, 1'b0);

    // R4: interrupt with unaligned PC keeps return address, aligned PC loads it
    issue(13'h1000, 64'h0000_0000_0000_4442, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0);
    issue(13'h1000, 64'h0000_0000_0000_5550, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0);
    // R5: trap with unaligned PC still loads PC then adds 4
    issue(13'h0400, 64'h0000_0000_0000_7773, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0);
    issue(13'h0800, 64'h0000_0000_0009_0000, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0);

    // R8: suppression for page-table-entry loads and prefetches
    issue(13'h0010, 64'h100, 64'h0000_0011_2222_0000, 32'hffff_ffff, 6'h3f, 1'b1, 1'b0);
    issue(13'h0080, 64'h104, 64'h0000_0033_4444_0000, 32'hffff_ffff, 6'h3f, 1'b0, 1'b1);
    issue(13'h0020, 64'h108, 64'h0000_0055_6666_0000, 32'h0fe0_0000, 6'h2a, 1'b0, 1'b0);

    // R3: priority among simultaneous requests
    issue(13'h0021, 64'h200, 64'h0000_0001_0000_0000, 32'h1234_5678, 6'h11, 1'b0, 1'b0);
    issue(13'h0088, 64'h0000_0042_0000_2000, 64'h0000_0077_0000_0000, 32'h8765_4321, 6'h22, 1'b0, 1'b0);
    issue(13'h1002, 64'h0000_0000_0000_0301, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0);
    issue(13'h0140, 64'h400, 64'h0000_0066_8000_0000, 32'hc3c3_c3c3, 6'h15, 1'b0, 1'b0);

    // R13: idle cycles leave capture registers unchanged
    repeat (4) @(negedge clk);
    check("R13", "exc_addr", exc_addr, m_ea);
    check("R13", "fault_va", fault_va, m_fva);
    check("R13", "va_form", va_form, m_form);
    check("R13", "iva_form", iva_form, m_iform);
    check("R2", "redir_valid idle", {63'b0, redir_valid}, 64'd0);

    // R10: saturation
    for (int k = 0; k < 260; k++) issue(13'h0200, 64'h800, 64'h0, 32'h0, 6'h0, 1'b0, 1'b0);
    for (int s = 0; s < 13; s++) cnt_read(4'(s), m_cnt[s], "R10");
    cnt_read(4'd14, 0, "R10");

    repeat (3) @(negedge clk);
    check("R2", "scoreboard drained", 64'(sb_q.size()), 64'd0);
    finish_run();
  end
endmodule